// File: doc/BRIEF.md
# Hsiao SECDED Word Checker

This block examines one 32-bit data word read from a memory together with the 7-bit check code stored beside it. It regenerates the check code from the data using a Hsiao code, in which every data bit feeds exactly three check bits. It XORs the result with the stored code to form a 7-bit syndrome. From that syndrome it decides whether the word is clean, holds a single correctable error, or holds an error it cannot repair. When the error is a single data bit, it flips that bit on the way out.

The stored word is never rewritten here. The corrected value, the syndrome and two flags are offered to whatever consumes the read. The flags are a correctable flag and an uncorrectable flag.

The decode is a cone of combinational logic. A parameter selects whether a register stage sits at the output. In the default build the results appear one clock after the inputs.

Top module: `hsiao_secded_decoder`

## Requirements
- R1: Data bit i uses as its column the i-th 7-bit value with exactly three ones, counted in ascending numeric order from 0 (bit 0 gets 0x07, bit 1 gets 0x0B). Check bit j uses the column 1<<j. Syndrome bit j is the stored check bit j XOR the XOR of all data bits whose column has bit j set. The syndrome is reported on `out_syndrome`.
- R2: A zero syndrome passes the data through unchanged, with both flags low.
- R3: A syndrome equal to the column of data bit i inverts bit i of the output data and raises the correctable flag.
- R4: A syndrome with exactly one bit set points to a check-bit error. The data passes unchanged and the correctable flag rises.
- R5: A nonzero syndrome with an even number of ones raises the uncorrectable flag, and the data passes unchanged.
- R6: A syndrome with an odd number of ones that matches no column raises the uncorrectable flag, and the data passes unchanged. This covers the three unused weight-3 values 0x64, 0x68 and 0x70, every weight-5 value, and 0x7F.
- R7: The two flags are never high together. Both are low whenever the valid strobe is low.
- R8: With the output register enabled (the default), every output reflects the inputs sampled at the previous rising clock edge, and `out_valid` repeats `in_valid` one cycle late. A synchronous active-high reset drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the data and check inputs as a word to be checked |
| in_data | input | 32 | Data word as read from memory |
| in_check | input | 7 | Check code as read from memory |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Data after correction |
| out_syndrome | output | 7 | Syndrome of the word |
| out_corr | output | 1 | Single error found and handled |
| out_uncorr | output | 1 | Error found that cannot be corrected |

## Verification
Clean words with several data patterns and correctly generated check codes confirm the encoding matrix and the zero-syndrome path. Walking a single flipped bit across all 32 data positions and then all 7 check positions separates a data repair from a check-bit report. It also shows that each column steers exactly one output bit. Pairs of flipped bits, and syndromes forced to the unused weight-3 values, to weight 5 and to 0x7F, tell the even-weight rule apart from the added odd-weight rejection that a bare parity test would miss. An erroneous word presented with the strobe low, and a look at the outputs before the capturing edge, confirm the flag gating and the one-cycle latency.

// File: rtl/hsiao_pkg.sv
package hsiao_pkg;
  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned CHK_W_DEF  = 7;

  // idx-th value of cw bits with exactly three ones, ascending order
  function automatic int unsigned col_code(int unsigned idx, int unsigned cw);
    int unsigned seen;
    int unsigned res;
    bit          found;
    seen  = 0;
    res   = 0;
    found = 1'b0;
    for (int unsigned v = 0; v < (32'd1 << cw); v++) begin
      if (!found && $countones(v) == 3) begin
        if (seen == idx) begin
          res   = v;
          found = 1'b1;
        end
        seen++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/hsiao_check_gen.sv
module hsiao_check_gen #(
  parameter int unsigned DW = hsiao_pkg::DATA_W_DEF,
  parameter int unsigned CW = hsiao_pkg::CHK_W_DEF
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] code
);
  logic [CW-1:0] cols [DW];

  for (genvar i = 0; i < DW; i++) begin : g_col
    localparam int unsigned CV = hsiao_pkg::col_code(i, CW);
    assign cols[i] = CV[CW-1:0];
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < DW; i++) begin
      code = code ^ (cols[i] & {CW{data[i]}});
    end
  end
endmodule

// File: rtl/hsiao_syndrome_eval.sv
module hsiao_syndrome_eval #(
  parameter int unsigned DW = hsiao_pkg::DATA_W_DEF,
  parameter int unsigned CW = hsiao_pkg::CHK_W_DEF
) (
  input  logic          valid,
  input  logic [CW-1:0] syn,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] fixed,
  output logic          corr,
  output logic          uncorr
);
  logic [DW-1:0] hit;
  logic          chk_hit;
  logic          nonzero;
  logic          legal;

  for (genvar i = 0; i < DW; i++) begin : g_hit
    localparam int unsigned CV = hsiao_pkg::col_code(i, CW);
    assign hit[i] = (syn == CV[CW-1:0]);
  end

  assign chk_hit = $onehot(syn);
  assign nonzero = |syn;
  assign legal   = (|hit) | chk_hit;

  assign fixed  = data ^ hit;
  assign corr   = valid & legal;
  assign uncorr = valid & nonzero & ~legal;
endmodule

// File: rtl/hsiao_secded_decoder.sv
module hsiao_secded_decoder #(
  parameter int unsigned DW      = hsiao_pkg::DATA_W_DEF,
  parameter int unsigned CW      = hsiao_pkg::CHK_W_DEF,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] in_check,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] out_syndrome,
  output logic          out_corr,
  output logic          out_uncorr
);
  logic [CW-1:0] regen;
  logic [CW-1:0] syn_c;
  logic [DW-1:0] fixed_c;
  logic          corr_c;
  logic          uncorr_c;

  hsiao_check_gen #(.DW(DW), .CW(CW)) u_gen (
    .data (in_data),
    .code (regen)
  );

  assign syn_c = regen ^ in_check;

  hsiao_syndrome_eval #(.DW(DW), .CW(CW)) u_eval (
    .valid  (in_valid),
    .syn    (syn_c),
    .data   (in_data),
    .fixed  (fixed_c),
    .corr   (corr_c),
    .uncorr (uncorr_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid    <= 1'b0;
        out_data     <= '0;
        out_syndrome <= '0;
        out_corr     <= 1'b0;
        out_uncorr   <= 1'b0;
      end else begin
        out_valid    <= in_valid;
        out_data     <= fixed_c;
        out_syndrome <= syn_c;
        out_corr     <= corr_c;
        out_uncorr   <= uncorr_c;
      end
    end
  end else begin : g_comb
    assign out_valid    = in_valid;
    assign out_data     = fixed_c;
    assign out_syndrome = syn_c;
    assign out_corr     = corr_c;
    assign out_uncorr   = uncorr_c;
  end
endmodule

// File: rtl/hsiao_secded_chk.sv
module hsiao_secded_chk #(
  parameter int unsigned DW      = hsiao_pkg::DATA_W_DEF,
  parameter int unsigned CW      = hsiao_pkg::CHK_W_DEF,
  parameter bit          REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic [CW-1:0] out_syndrome,
  input logic          out_corr,
  input logic          out_uncorr
);
  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(out_corr && out_uncorr));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_corr && !out_uncorr));

  p_clean_word_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_syndrome == '0) |-> (!out_corr && !out_uncorr));

  p_even_weight_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (|out_syndrome) && !(^out_syndrome)) |-> out_uncorr);

  p_corr_odd_r3: assert property (@(posedge clk) disable iff (rst)
    out_corr |-> (^out_syndrome));

  if (REG_OUT) begin : g_seq
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

    p_idle_follow_r8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

    p_uncorr_passthru_r6: assert property (@(posedge clk) disable iff (rst)
      out_uncorr |-> (out_data == $past(in_data)));
  end
endmodule

bind hsiao_secded_decoder hsiao_secded_chk #(
  .DW(DW), .CW(CW), .REG_OUT(REG_OUT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_data      (in_data),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_syndrome (out_syndrome),
  .out_corr     (out_corr),
  .out_uncorr   (out_uncorr)
);

// File: tb/tb_hsiao_secded_decoder.sv
module tb_hsiao_secded_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [6:0]  in_check = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [6:0]  out_syndrome;
  logic        out_corr;
  logic        out_uncorr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsiao_secded_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_check(in_check), .out_valid(out_valid), .out_data(out_data),
    .out_syndrome(out_syndrome), .out_corr(out_corr), .out_uncorr(out_uncorr)
  );

  // reference column: i-th 7-bit value of weight three, ascending
  function automatic logic [6:0] ref_col(int idx);
    int n;
    n = 0;
    for (int v = 0; v < 128; v++) begin
      int w;
      w = 0;
      for (int b = 0; b < 7; b++) w += (v >> b) & 1;
      if (w == 3) begin
        if (n == idx) return v[6:0];
        n++;
      end
    end
    return 7'h00;
  endfunction

  function automatic logic [6:0] ref_enc(logic [31:0] d);
    logic [6:0] c;
    c = '0;
    for (int i = 0; i < 32; i++) if (d[i]) c ^= ref_col(i);
    return c;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge capture, sample at next falling edge
  task automatic apply(logic v, logic [31:0] d, logic [6:0] c);
    in_valid = v;
    in_data  = d;
    in_check = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(string req, logic v, logic [31:0] d, logic [6:0] s, logic cr, logic uc);
    chk(out_valid == v,    req, "valid",    64'(out_valid),    64'(v));
    chk(out_data == d,     req, "data",     64'(out_data),     64'(d));
    chk(out_syndrome == s, req, "syndrome", 64'(out_syndrome), 64'(s));
    chk(out_corr == cr,    req, "corr",     64'(out_corr),     64'(cr));
    chk(out_uncorr == uc,  req, "uncorr",   64'(out_uncorr),   64'(uc));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    in_valid = 1'b1;
    in_data = 32'hFFFF_FFFF;
    in_check = 7'h00;
    @(posedge clk);
    @(negedge clk);
    expect_out("R8 reset", 1'b0, 32'h0, 7'h0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_clean();
    logic [31:0] pats [6];
    pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h1234_5678, 32'h8000_0001, 32'hA5A5_5A5A};
    for (int p = 0; p < 6; p++) begin
      apply(1'b1, pats[p], ref_enc(pats[p]));
      expect_out("R2 clean", 1'b1, pats[p], 7'h00, 1'b0, 1'b0);
    end
    // R1: wrong stored code gives syndrome equal to stored XOR regenerated
    apply(1'b1, 32'h0000_0001, 7'h00);
    chk(out_syndrome == 7'h07, "R1", "bit0 column", 64'(out_syndrome), 64'h07);
    apply(1'b1, 32'h0000_0002, 7'h00);
    chk(out_syndrome == 7'h0B, "R1", "bit1 column", 64'(out_syndrome), 64'h0B);
  endtask

  task automatic t_data_single();
    logic [31:0] base [2];
    base = '{32'hCAFE_F00D, 32'h0F0F_0F0F};
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 32; i++) begin
        logic [31:0] bad;
        bad = base[p] ^ (32'h1 << i);
        apply(1'b1, bad, ref_enc(base[p]));
        expect_out("R3 data flip", 1'b1, base[p], ref_col(i), 1'b1, 1'b0);
      end
    end
  endtask

  task automatic t_check_single();
    logic [31:0] d;
    d = 32'h3C3C_9669;
    for (int j = 0; j < 7; j++) begin
      apply(1'b1, d, ref_enc(d) ^ (7'h1 << j));
      expect_out("R4 check flip", 1'b1, d, 7'h1 << j, 1'b1, 1'b0);
    end
  endtask

  task automatic t_double();
    logic [31:0] d;
    logic [31:0] bad;
    d = 32'h7654_3210;
    for (int i = 0; i < 31; i += 5) begin
      bad = d ^ (32'h1 << i) ^ (32'h1 << (i + 1));
      apply(1'b1, bad, ref_enc(d));
      expect_out("R5 two data bits", 1'b1, bad, ref_col(i) ^ ref_col(i + 1), 1'b0, 1'b1);
    end
    bad = d ^ 32'h0000_0100;
    apply(1'b1, bad, ref_enc(d) ^ 7'h01);
    expect_out("R5 data plus check", 1'b1, bad, ref_col(8) ^ 7'h01, 1'b0, 1'b1);
  endtask

  task automatic t_odd_nomatch();
    logic [6:0]  s [5];
    logic [31:0] d;
    s = '{7'h64, 7'h68, 7'h70, 7'h1F, 7'h7F};
    d = 32'h0BAD_C0DE;
    for (int k = 0; k < 5; k++) begin
      apply(1'b1, d, ref_enc(d) ^ s[k]);
      expect_out("R6 odd no match", 1'b1, d, s[k], 1'b0, 1'b1);
    end
  endtask

  task automatic t_idle();
    logic [31:0] d;
    d = 32'h1111_2222;
    apply(1'b0, d ^ 32'h10, ref_enc(d));
    chk(out_valid == 1'b0, "R7 idle", "valid", 64'(out_valid), 64'h0);
    chk(out_corr == 1'b0, "R7 idle", "corr", 64'(out_corr), 64'h0);
    chk(out_uncorr == 1'b0, "R7 idle", "uncorr", 64'(out_uncorr), 64'h0);
    apply(1'b0, d, ref_enc(d) ^ 7'h03);
    chk(out_uncorr == 1'b0, "R7 idle even", "uncorr", 64'(out_uncorr), 64'h0);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    d = 32'h5555_AAAA;
    apply(1'b1, d, ref_enc(d));
    // new erroneous input, outputs must still hold the previous clean word
    in_valid = 1'b1;
    in_data  = d ^ 32'h4;
    in_check = ref_enc(d);
    #1;
    chk(out_corr == 1'b0, "R8 latency", "corr before edge", 64'(out_corr), 64'h0);
    chk(out_data == d, "R8 latency", "data before edge", 64'(out_data), 64'(d));
    @(posedge clk);
    @(negedge clk);
    chk(out_corr == 1'b1, "R8 latency", "corr after edge", 64'(out_corr), 64'h1);
    chk(out_data == d, "R8 latency", "data after edge", 64'(out_data), 64'(d));
    apply(1'b0, 32'h0, 7'h0);
    chk(out_valid == 1'b0, "R8 latency", "valid drop", 64'(out_valid), 64'h0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_clean();
    t_data_single();
    t_check_single();
    t_double();
    t_odd_nomatch();
    t_idle();
    t_latency();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule